// File: doc/BRIEF.md
# Ingress Segment Reassembly and Frame Decapsulation

This block sits on the receive side of a multi-channel aggregation link. Segments arrive one byte per beat on a single shared input. Each beat carries a channel number and start and end flags. The block steers every beat into a buffer owned by that channel, rebuilds whole frames there and hands them, one byte per beat, to the transmit side of the matching port. Each port has a ready input that can stall it.

Two framing modes exist and one configuration bit selects between them:

- **Encapsulated mode.** Every frame starts with a 4-byte scrambled core header and a 4-byte payload header.
  - The block checks the core header, compares the length it carries with the byte count actually received, and strips both headers.
  - Only a frame that was received whole and passed every check is released, so this mode is store-and-forward.
- **Pass-through mode.** Bytes are stored untouched.
  - A frame starts leaving once the bytes buffered for it reach a programmable threshold, or once it has been closed.

For every channel the block also drives a 2-bit fill code back toward the sender. The code is derived from two programmable fill levels, so the sender can pace each channel.

Top module: `ing_reasm`

## Requirements
- R1: A beat with channel number c is stored only in the buffer of channel c and leaves only on transmit port c, in arrival order. The first byte of each forwarded frame is flagged start and its last byte is flagged end.
- R2: After reset, no port is valid and every fill code is 00.
- R3: In encapsulated mode, the first 8 bytes of a frame are never forwarded. A frame's first byte is not offered until the beat carrying its end flag has been accepted and the frame has been judged good.
- R4: In encapsulated mode, header bytes 0..3 are XORed with B6, AB, 31 and E0 respectively. The result is a 16-bit length (bytes 0 and 1, MSB first) followed by a 16-bit check value. The check value must equal the CRC-16 of the length, computed with polynomial 0x1021, initial value 0, most significant bit first. On a mismatch the whole frame is discarded.
- R5: In encapsulated mode, the length must equal the number of bytes received after the 4-byte core header. It must also be at least 5, so that at least one payload byte remains. Otherwise the frame is discarded.
- R6: In pass-through mode, all bytes are forwarded unchanged. An idle port begins a frame when the stored count reaches cfg_cut_thr, or earlier if that frame is already closed.
- R7: A start beat arriving while a frame is open on the same channel aborts the open frame.
  - In encapsulated mode, the aborted frame is discarded.
  - In pass-through mode, its bytes are forwarded and then closed by one extra beat with end=1, err=1 and data 00. The new frame follows.
  - err is never set otherwise.
- R8: The fill code is computed from the channel's stored byte count, including bytes of a frame still being received. The code is 00 below cfg_low_thr, 01 from cfg_low_thr up to below cfg_high_thr, and 10 at or above cfg_high_thr.
- R9: While a port is valid and its ready is low, its data, start, end and err outputs hold their values.
- R10: A beat with neither a start flag nor an open frame on its channel is ignored: it changes neither the outputs nor the fill code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_gfp | input | 1 | 1 selects encapsulated store-and-forward mode, 0 selects pass-through |
| cfg_cut_thr | input | AW+1 | Pass-through start threshold in bytes |
| cfg_low_thr | input | AW+1 | Fill level at which the code leaves 00 |
| cfg_high_thr | input | AW+1 | Fill level at which the code becomes 10 |
| in_valid | input | 1 | Input beat present |
| in_chan | input | CW | Channel number of the beat |
| in_sop | input | 1 | Beat starts a frame |
| in_eop | input | 1 | Beat ends a frame |
| in_data | input | 8 | Beat byte |
| tx_ready | input | N_CH | Per-port ready |
| tx_valid | output | N_CH | Per-port byte valid |
| tx_data | output | 8*N_CH | Per-port byte, port c at bits 8c+7..8c |
| tx_sop | output | N_CH | First byte of a frame |
| tx_eop | output | N_CH | Last byte of a frame |
| tx_err | output | N_CH | Frame ended by an abort |
| stat | output | 2*N_CH | Fill code of channel c at bits 2c+1..2c |

## Verification
The bench interleaves short segments of several channels on the shared input. A design that steered by the wrong channel, or mixed queues, would show foreign bytes on a port.

Encapsulated frames are sent in four forms:
- good;
- with a corrupted check value;
- with a length one larger than the data;
- truncated inside the headers.

A design that skipped a check, or released a frame before its end, would forward bytes the model does not expect.

In pass-through mode, a frame is held just below the start threshold and another is aborted mid-stream. This exposes a design that starts early, never starts a short closed frame, or loses the terminating error beat. Random back-pressure checks that stalled outputs hold still, and that the fill code follows stored bytes, including bytes of an incomplete frame.

// File: rtl/ing_reasm_pkg.sv
package ing_reasm_pkg;

    localparam int          CORE_BYTES    = 4;
    localparam int          GFP_HDR_BYTES = 8;
    localparam logic [31:0] CORE_SCRAMBLE = 32'hB6AB_31E0;

    // one stored byte; 'term' marks that the frame before it was aborted
    typedef struct packed {
        logic       term;
        logic       eop;
        logic [7:0] data;
    } ent_t;

    typedef enum logic [1:0] {
        FILL_STARVE = 2'b00,
        FILL_HUNGRY = 2'b01,
        FILL_SATED  = 2'b10
    } fill_code_e;

    function automatic logic [15:0] crc16_ccitt0(input logic [15:0] v);
        logic [15:0] c;
        logic        fb;
        c = '0;
        for (int b = 15; b >= 0; b--) begin
            fb = c[15] ^ v[b];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    function automatic fill_code_e fill_code(input logic [15:0] f,
                                             input logic [15:0] lo,
                                             input logic [15:0] hi);
        if (f >= hi)      return FILL_SATED;
        else if (f >= lo) return FILL_HUNGRY;
        else              return FILL_STARVE;
    endfunction

endpackage

// File: rtl/ing_core_hdr.sv
module ing_core_hdr
    import ing_reasm_pkg::*;
(
    input  logic [31:0] raw,
    output logic [15:0] pli,
    output logic        hec_ok
);
    logic [31:0] plain;

    always_comb begin
        plain  = raw ^ CORE_SCRAMBLE;
        pli    = plain[31:16];
        hec_ok = (crc16_ccitt0(plain[31:16]) == plain[15:0]);
    end
endmodule

// File: rtl/ing_lane.sv
module ing_lane
    import ing_reasm_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_gfp,
    input  logic [AW:0]   cfg_cut_thr,
    input  logic [AW:0]   cfg_low_thr,
    input  logic [AW:0]   cfg_high_thr,
    input  logic          beat_en,
    input  logic          in_sop,
    input  logic          in_eop,
    input  logic [7:0]    in_data,
    input  logic          tx_ready,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_sop,
    output logic          tx_eop,
    output logic          tx_err,
    output logic [1:0]    stat
);
    localparam logic [AW:0] ONE = (AW+1)'(1);

    ent_t        mem [DEPTH];
    logic [AW:0] wr, rd, fstart, done;
    logic        open, mid;
    logic [15:0] idx;
    logic [31:0] hdr;

    logic        wr_do;
    ent_t        wr_ent;
    logic [AW:0] wr_nxt, fst_nxt, avail;
    logic        open_nxt, frame_ok, has, term_cyc, fire, pop, dec;
    logic [1:0]  close;
    logic [15:0] idx_nxt, pli;
    logic [31:0] hdr_nxt;
    logic        hec_ok;
    ent_t        head;

    ing_core_hdr u_hdr (.raw(hdr), .pli(pli), .hec_ok(hec_ok));

    assign frame_ok = (idx >= 16'(GFP_HDR_BYTES)) && hec_ok && (pli == idx - 16'd3);

    // ---------------- write side: steer, strip, check, commit or rewind
    always_comb begin
        wr_do    = 1'b0;
        wr_ent   = '0;
        wr_nxt   = wr;
        fst_nxt  = fstart;
        open_nxt = open;
        close    = 2'd0;
        idx_nxt  = idx;
        hdr_nxt  = hdr;
        if (beat_en) begin
            if (cfg_gfp) begin
                if (in_sop) begin
                    wr_nxt   = open ? fstart : wr;
                    fst_nxt  = wr_nxt;
                    open_nxt = !in_eop;
                    idx_nxt  = 16'd1;
                    hdr_nxt  = {24'd0, in_data};
                end else if (open) begin
                    if (idx < 16'(CORE_BYTES)) begin
                        hdr_nxt = {hdr[23:0], in_data};
                    end else if (idx >= 16'(GFP_HDR_BYTES)) begin
                        wr_do  = 1'b1;
                        wr_ent = '{term: 1'b0, eop: in_eop, data: in_data};
                        wr_nxt = wr + ONE;
                    end
                    idx_nxt = (idx == 16'hFFFF) ? idx : idx + 16'd1;
                    if (in_eop) begin
                        open_nxt = 1'b0;
                        if (frame_ok) begin
                            close   = 2'd1;
                            fst_nxt = wr_nxt;
                        end else begin
                            wr_nxt  = fstart;
                        end
                    end
                end
            end else if (in_sop || open) begin
                wr_do    = 1'b1;
                wr_ent   = '{term: in_sop && open, eop: in_eop, data: in_data};
                wr_nxt   = wr + ONE;
                close    = {1'b0, in_sop && open} + {1'b0, in_eop};
                open_nxt = !in_eop;
            end
        end
    end

    // ---------------- read side: gate start, emit terminator, drain
    always_comb begin
        avail    = wr - rd;
        head     = mem[rd[AW-1:0]];
        has      = (avail != '0);
        term_cyc = mid && has && head.term;
        tx_valid = mid ? has
                       : (has && ((done != '0) || (!cfg_gfp && avail >= cfg_cut_thr)));
        tx_data  = term_cyc ? 8'h00 : head.data;
        tx_sop   = !mid;
        tx_eop   = term_cyc || head.eop;
        tx_err   = term_cyc;
        fire     = tx_valid && tx_ready;
        pop      = fire && !term_cyc;
        dec      = fire && tx_eop;
        stat     = fill_code(16'(avail), 16'(cfg_low_thr), 16'(cfg_high_thr));
    end

    always_ff @(posedge clk) begin
        if (wr_do) mem[wr[AW-1:0]] <= wr_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr     <= '0;
            rd     <= '0;
            fstart <= '0;
            done   <= '0;
            open   <= 1'b0;
            mid    <= 1'b0;
            idx    <= '0;
            hdr    <= '0;
        end else begin
            wr     <= wr_nxt;
            fstart <= fst_nxt;
            open   <= open_nxt;
            idx    <= idx_nxt;
            hdr    <= hdr_nxt;
            if (pop)  rd  <= rd + ONE;
            if (fire) mid <= !tx_eop;
            done   <= done + (AW+1)'(close) - (AW+1)'(dec);
        end
    end
endmodule

// File: rtl/ing_reasm.sv
module ing_reasm
    import ing_reasm_pkg::*;
#(
    parameter  int N_CH  = 4,
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_gfp,
    input  logic [AW:0]       cfg_cut_thr,
    input  logic [AW:0]       cfg_low_thr,
    input  logic [AW:0]       cfg_high_thr,
    input  logic              in_valid,
    input  logic [CW-1:0]     in_chan,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [7:0]        in_data,
    input  logic [N_CH-1:0]   tx_ready,
    output logic [N_CH-1:0]   tx_valid,
    output logic [8*N_CH-1:0] tx_data,
    output logic [N_CH-1:0]   tx_sop,
    output logic [N_CH-1:0]   tx_eop,
    output logic [N_CH-1:0]   tx_err,
    output logic [2*N_CH-1:0] stat
);
    for (genvar g = 0; g < N_CH; g++) begin : g_lane
        logic sel;
        assign sel = in_valid && (in_chan == CW'(g));

        ing_lane #(.DEPTH(DEPTH)) u_lane (
            .clk          (clk),
            .rst          (rst),
            .cfg_gfp      (cfg_gfp),
            .cfg_cut_thr  (cfg_cut_thr),
            .cfg_low_thr  (cfg_low_thr),
            .cfg_high_thr (cfg_high_thr),
            .beat_en      (sel),
            .in_sop       (in_sop),
            .in_eop       (in_eop),
            .in_data      (in_data),
            .tx_ready     (tx_ready[g]),
            .tx_valid     (tx_valid[g]),
            .tx_data      (tx_data[8*g +: 8]),
            .tx_sop       (tx_sop[g]),
            .tx_eop       (tx_eop[g]),
            .tx_err       (tx_err[g]),
            .stat         (stat[2*g +: 2])
        );
    end
endmodule

// File: rtl/ing_reasm_chk.sv
module ing_reasm_chk #(
    parameter int N_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_gfp,
    input logic [N_CH-1:0]   tx_ready,
    input logic [N_CH-1:0]   tx_valid,
    input logic [8*N_CH-1:0] tx_data,
    input logic [N_CH-1:0]   tx_sop,
    input logic [N_CH-1:0]   tx_eop,
    input logic [N_CH-1:0]   tx_err,
    input logic [2*N_CH-1:0] stat
);
    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (tx_valid == '0) && (stat == '0)); // R2

    for (genvar g = 0; g < N_CH; g++) begin : g_c
        logic infr;
        always_ff @(posedge clk) begin
            if (rst) infr <= 1'b0;
            else if (tx_valid[g] && tx_ready[g]) infr <= !tx_eop[g];
        end

        AST_FRAME_ORDER: assert property (@(posedge clk) disable iff (rst)
            tx_valid[g] |-> (tx_sop[g] == !infr)); // R1
        AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
            (tx_valid[g] && !tx_ready[g]) |=> (tx_valid[g] && $stable(tx_data[8*g +: 8])
                && $stable(tx_sop[g]) && $stable(tx_eop[g]) && $stable(tx_err[g]))); // R9
        AST_TERM_FORM: assert property (@(posedge clk) disable iff (rst)
            (tx_valid[g] && tx_err[g]) |-> (tx_eop[g] && !tx_sop[g] && tx_data[8*g +: 8] == 8'h00)); // R7
        AST_ENC_NO_ERR: assert property (@(posedge clk) disable iff (rst)
            cfg_gfp |-> !(tx_valid[g] && tx_err[g])); // R7
        AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
            stat[2*g +: 2] != 2'b11); // R8
    end
endmodule

bind ing_reasm ing_reasm_chk #(.N_CH(N_CH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_gfp  (cfg_gfp),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_sop   (tx_sop),
    .tx_eop   (tx_eop),
    .tx_err   (tx_err),
    .stat     (stat)
);

// File: tb/ing_reasm_tb_top.sv
module ing_reasm_tb_top;
    localparam int N  = 4;
    localparam int DP = 64;
    localparam int AW = $clog2(DP);
    localparam int CW = $clog2(N);

    logic clk = 0, rst = 1;
    logic cfg_gfp = 0;
    logic [AW:0] cfg_cut_thr = 4, cfg_low_thr = 2, cfg_high_thr = 6;
    logic in_valid = 0, in_sop = 0, in_eop = 0;
    logic [CW-1:0] in_chan = 0;
    logic [7:0] in_data = 0;
    logic [N-1:0] tx_ready = '1;
    logic [N-1:0] tx_valid, tx_sop, tx_eop, tx_err;
    logic [8*N-1:0] tx_data;
    logic [2*N-1:0] stat;

    always #5 clk = ~clk;

    ing_reasm #(.N_CH(N), .DEPTH(DP)) dut_i (.*);

    // ---------------- reference model state
    int st [N][$];               // stored entries: term<<9 | eop<<8 | data
    byte unsigned gb [N][$];     // encapsulated frame under reception
    bit opn [N], mid [N], stall [N];
    int dn [N];
    int good_f [N], err_f [N];   // observed at the ports
    bit hold [N];
    bit rnd_rdy = 0;
    int n_cmp = 0, n_bad = 0;
    bit done_flag = 0;
    byte unsigned fr [N][$];

    function automatic int pend(int c);
        if (cfg_gfp && opn[c] && gb[c].size() > 8) return gb[c].size() - 8;
        return 0;
    endfunction

    function automatic logic [15:0] ref_crc(logic [15:0] v);
        logic [15:0] c = 0;
        for (int k = 0; k < 2; k++) begin
            c = c ^ (k == 0 ? {v[15:8], 8'h00} : {v[7:0], 8'h00});
            for (int b = 0; b < 8; b++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        return c;
    endfunction

    function automatic bit enc_ok(int c);
        int n = gb[c].size();
        logic [15:0] l, h;
        if (n < 9) return 0;
        l = {gb[c][0] ^ 8'hB6, gb[c][1] ^ 8'hAB};
        h = {gb[c][2] ^ 8'h31, gb[c][3] ^ 8'hE0};
        return (int'(l) == n - 4) && (ref_crc(l) == h);
    endfunction

    task automatic cmp(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_and_pop();
        for (int c = 0; c < N; c++) begin
            int sz = st[c].size();
            int f = sz + pend(c);
            bit ev, term;
            int hd = (sz > 0) ? st[c][0] : 0;
            int lo = int'(cfg_low_thr), hi = int'(cfg_high_thr);
            ev = mid[c] ? (sz > 0) : (sz > 0 && (dn[c] > 0 || (!cfg_gfp && sz >= int'(cfg_cut_thr))));
            term = mid[c] && sz > 0 && hd[9];
            cmp(cfg_gfp ? "R3 valid" : "R6 valid", int'(tx_valid[c]), int'(ev));
            cmp("R8 code", int'(stat[2*c +: 2]), f >= hi ? 2 : (f >= lo ? 1 : 0));
            if (ev) begin
                cmp(stall[c] ? "R9 data" : "R1 data", int'(tx_data[8*c +: 8]), term ? 0 : (hd & 255));
                cmp("R1 sop", int'(tx_sop[c]), int'(!mid[c]));
                cmp("R1 eop", int'(tx_eop[c]), int'(term || hd[8]));
                cmp("R7 err", int'(tx_err[c]), int'(term));
            end
            stall[c] = tx_valid[c] && !tx_ready[c];
            if (tx_valid[c] && tx_ready[c] && tx_eop[c]) begin
                if (tx_err[c]) err_f[c]++; else good_f[c]++;
            end
            if (ev && tx_ready[c]) begin
                if (term) begin mid[c] = 0; dn[c]--; end
                else begin
                    int e = st[c].pop_front();
                    if (e[8]) begin mid[c] = 0; dn[c]--; end else mid[c] = 1;
                end
            end
        end
    endtask

    task automatic model_write(int c, bit s, bit e, byte unsigned d);
        if (cfg_gfp) begin
            if (s) begin gb[c].delete(); gb[c].push_back(d); opn[c] = !e; end
            else if (opn[c]) begin
                gb[c].push_back(d);
                if (e) begin
                    opn[c] = 0;
                    if (enc_ok(c)) begin
                        for (int k = 8; k < gb[c].size(); k++)
                            st[c].push_back(((k == gb[c].size() - 1) ? 256 : 0) | gb[c][k]);
                        dn[c]++;
                    end
                    gb[c].delete();
                end
            end
        end else if (s || opn[c]) begin
            st[c].push_back(((s && opn[c]) ? 512 : 0) | (e ? 256 : 0) | d);
            dn[c] += (s && opn[c] ? 1 : 0) + (e ? 1 : 0);
            opn[c] = !e;
        end
    endtask

    task automatic beat(bit v, int c, bit s, bit e, byte unsigned d);
        @(negedge clk);
        in_valid = v; in_chan = CW'(c); in_sop = s; in_eop = e; in_data = d;
        for (int k = 0; k < N; k++) tx_ready[k] = hold[k] ? 1'b0 : (rnd_rdy ? 1'($urandom % 2) : 1'b1);
        #1;
        check_and_pop();
        if (v) model_write(c, s, e, d);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) beat(0, 0, 0, 0, 0);
    endtask

    task automatic drain();
        for (int i = 0; i < 600; i++) begin
            bit busy = 0;
            for (int c = 0; c < N; c++) if (st[c].size() != 0 || mid[c]) busy = 1;
            if (!busy) break;
            beat(0, 0, 0, 0, 0);
        end
    endtask

    task automatic build_pt(int c, int n, int base);
        fr[c].delete();
        for (int i = 0; i < n; i++) fr[c].push_back(byte'(base + i));
    endtask

    task automatic build_enc(int c, int plen, int base, bit bad_hec, int len_adj);
        logic [15:0] l = 16'(plen + 4 + len_adj);
        logic [15:0] h = ref_crc(l) ^ (bad_hec ? 16'h0001 : 16'h0000);
        fr[c].delete();
        fr[c].push_back(l[15:8] ^ 8'hB6); fr[c].push_back(l[7:0] ^ 8'hAB);
        fr[c].push_back(h[15:8] ^ 8'h31); fr[c].push_back(h[7:0] ^ 8'hE0);
        fr[c].push_back(8'h00); fr[c].push_back(8'h01); fr[c].push_back(8'hA5); fr[c].push_back(8'h5A);
        for (int i = 0; i < plen; i++) fr[c].push_back(byte'(base + 3 * i));
    endtask

    // send all built frames, interleaved in segments of 'seg' bytes
    task automatic send_all(int seg);
        int pos [N];
        bit more = 1;
        for (int c = 0; c < N; c++) pos[c] = 0;
        while (more) begin
            more = 0;
            for (int c = 0; c < N; c++) begin
                for (int k = 0; k < seg && pos[c] < fr[c].size(); k++) begin
                    beat(1, c, pos[c] == 0, pos[c] == fr[c].size() - 1, fr[c][pos[c]]);
                    pos[c]++;
                end
                if (pos[c] < fr[c].size()) more = 1;
            end
        end
        for (int c = 0; c < N; c++) fr[c].delete();
    endtask

    task automatic set_mode(bit g, int thr);
        @(negedge clk);
        cfg_gfp = g; cfg_cut_thr = (AW+1)'(thr);
    endtask

    initial begin : wd
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        int g0 [N];
        int e0 [N];
        for (int c = 0; c < N; c++) begin opn[c] = 0; mid[c] = 0; dn[c] = 0; good_f[c] = 0; err_f[c] = 0; hold[c] = 0; stall[c] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        cmp("R2 reset valid", int'(tx_valid), 0);
        cmp("R2 reset code", int'(stat), 0);

        // pass-through, interleaved, random back-pressure (R1 R6 R9)
        set_mode(0, 4);
        rnd_rdy = 1;
        for (int r = 0; r < 3; r++) begin
            for (int c = 0; c < N; c++) build_pt(c, 5 + 3 * c + r, 16 * c + r);
            send_all(2 + r);
        end
        drain();
        rnd_rdy = 0;

        // R10: stray beats with no open frame on channel 3
        for (int i = 0; i < 4; i++) beat(1, 3, 0, i == 3, 8'hEE);
        idle(2);
        cmp("R10 stray code", int'(stat[7:6]), 0);
        cmp("R10 stray valid", int'(tx_valid[3]), 0);

        // R6: below threshold stays quiet, reaching it starts
        set_mode(0, 8);
        for (int i = 0; i < 5; i++) beat(1, 1, i == 0, 0, byte'(i));
        idle(3);
        cmp("R6 below thr", int'(tx_valid[1]), 0);
        for (int i = 5; i < 8; i++) beat(1, 1, 0, 0, byte'(i));
        idle(1);
        for (int i = 8; i < 10; i++) beat(1, 1, 0, i == 9, byte'(i));
        drain();
        // R6: short closed frame leaves although below threshold
        build_pt(2, 3, 8'h70);
        send_all(3);
        drain();
        cmp("R6 short frame", good_f[2] > 0 ? 1 : 0, 1);

        // R8: fill codes with a stalled port
        hold[1] = 1;
        for (int i = 0; i < 7; i++) beat(1, 1, i == 0, 0, byte'(i));
        idle(1);
        cmp("R8 sated", int'(stat[3:2]), 2);
        beat(1, 1, 0, 1, 8'h07);
        hold[1] = 0;
        drain();
        cmp("R8 empty", int'(stat[3:2]), 0);

        // R7 pass-through abort
        set_mode(0, 4);
        for (int c = 0; c < N; c++) begin g0[c] = good_f[c]; e0[c] = err_f[c]; end
        for (int i = 0; i < 5; i++) beat(1, 2, i == 0, 0, byte'(8'h40 + i));
        build_pt(2, 3, 8'h50);
        send_all(3);
        drain();
        cmp("R7 pt err frames", err_f[2] - e0[2], 1);
        cmp("R7 pt good frames", good_f[2] - g0[2], 1);

        // encapsulated: good, bad check, bad length, good (R3 R4 R5)
        set_mode(1, 4);
        rnd_rdy = 1;
        for (int c = 0; c < N; c++) begin g0[c] = good_f[c]; e0[c] = err_f[c]; end
        build_enc(0, 12, 8'h11, 0, 0);
        build_enc(1, 10, 8'h22, 1, 0);
        build_enc(2, 9, 8'h33, 0, 1);
        build_enc(3, 1, 8'h44, 0, 0);
        send_all(3);
        drain();
        cmp("R4 good ch0", good_f[0] - g0[0], 1);
        cmp("R4 bad check ch1", good_f[1] - g0[1], 0);
        cmp("R5 bad length ch2", good_f[2] - g0[2], 0);
        cmp("R5 one byte ch3", good_f[3] - g0[3], 1);
        rnd_rdy = 0;

        // R3: nothing leaves before end; R5 truncated header frame
        build_enc(0, 6, 8'h60, 0, 0);
        for (int i = 0; i < fr[0].size() - 1; i++) beat(1, 0, i == 0, 0, fr[0][i]);
        idle(2);
        cmp("R3 held before end", int'(tx_valid[0]), 0);
        beat(1, 0, 0, 1, fr[0][fr[0].size() - 1]);
        fr[0].delete();
        drain();
        g0[3] = good_f[3];
        for (int i = 0; i < 6; i++) beat(1, 3, i == 0, i == 5, 8'h00);
        drain();
        cmp("R5 truncated", good_f[3] - g0[3], 0);

        // R7 encapsulated abort: open frame discarded, next one good
        for (int c = 0; c < N; c++) begin g0[c] = good_f[c]; e0[c] = err_f[c]; end
        build_enc(1, 8, 8'h90, 0, 0);
        for (int i = 0; i < 11; i++) beat(1, 1, i == 0, 0, fr[1][i]);
        build_enc(1, 5, 8'hA0, 0, 0);
        send_all(4);
        drain();
        cmp("R7 enc good", good_f[1] - g0[1], 1);
        cmp("R7 enc no err", err_f[1] - e0[1], 0);

        idle(4);
        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule